// File: doc/BRIEF.md
# Warp Barrier Arrival Tracker

This block keeps count of the warps in a core that have reached each numbered synchronization barrier. Each arrival request carries a 32-bit barrier identifier, a requested warp count and the id of the arriving warp. The block keeps one arrival bit mask per barrier. The top bit of the identifier selects the kind of barrier, and the remaining 31 bits select which barrier.

A local barrier completes when the number of distinct warps that have arrived equals the requested count. The block then reports the set of arrived warps as a resume mask, so the scheduler can wake them. A global barrier completes when every warp in the core's active-warp mask has arrived. The block then raises a one-cycle request towards the cluster, carrying the barrier number, the requested count and the core id. In both cases the barrier's mask is cleared and can be used again.

The block accepts at most one arrival per clock. All results are registered and appear in the cycle after the arrival is accepted. If an arrival names a barrier number outside the configured range, the block raises an error pulse and changes no other state.

Top module: `warp_barrier_sync`

## Requirements
- R1: Reset clears every barrier arrival mask and drives all outputs to zero. Arrivals made before a reset do not count towards any barrier afterwards.
- R2: Bit 31 of `arr_bar_id` selects the barrier kind: 0 means local and 1 means global. Bits 30:0 give the barrier number.
- R3: An accepted arrival sets bit `arr_warp` of that barrier's mask. A repeated arrival of the same warp leaves the mask unchanged, so that warp is counted only once.
- R4: A local barrier completes when the popcount of its updated mask equals `arr_count`. The block then pulses `resume_valid` and presents that mask on `resume_mask` (bit w set means warp w arrived).
- R5: After a local barrier completes, its mask is empty.
- R6: A global barrier completes when the popcount of its updated mask equals the popcount of `active_mask`. The block then pulses `glb_valid` and presents the barrier number on `glb_bar`, `arr_count` on `glb_count` and `core_id` on `glb_core`.
- R7: After a global barrier completes, its mask is empty.
- R8: An arrival whose barrier number is `NUM_BARRIERS` or greater pulses `bad_index` and changes no barrier mask.
- R9: Every output pulse appears in the cycle after the arrival is accepted and lasts exactly one cycle. When no pulse is present, the payload outputs are zero.
- R10: An arrival changes only the mask of the barrier it names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Arrival request present this cycle |
| arr_bar_id | input | 32 | Bit 31 selects global; bits 30:0 give the barrier number |
| arr_count | input | CNT_W (3) | Requested number of warps |
| arr_warp | input | WID_W (2) | Id of the arriving warp |
| active_mask | input | NUM_WARPS (4) | Warps currently active in the core |
| core_id | input | CORE_ID_W (8) | Id of this core |
| resume_valid | output | 1 | Local barrier completed |
| resume_mask | output | NUM_WARPS (4) | Warps to resume |
| glb_valid | output | 1 | Global barrier request to the cluster |
| glb_bar | output | 31 | Barrier number of the global request |
| glb_count | output | CNT_W (3) | Count carried with the global request |
| glb_core | output | CORE_ID_W (8) | Core id carried with the global request |
| bad_index | output | 1 | Arrival named a barrier that does not exist |

## Verification
The hardest states to reach from the ports are those where a barrier holds a partial mask that is then disturbed. The disturbance may be a repeated warp, an arrival at a neighbouring barrier, an out-of-range number that would alias onto it after truncation, or a reset. The bench builds each partial state with chosen arrivals, applies the disturbance, and then completes the barrier. The size of the resume mask, or the absence of a completion, then shows whether the hidden mask was corrupted. Full sweeps over every warp subset for each barrier, and over every active mask for global barriers, cover the completion compares.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   localparam int ID_W       = 32;
   localparam int SCOPE_BIT  = 31;
   localparam int BARNUM_W   = 31;

   typedef enum logic {
      SCOPE_LOCAL  = 1'b0,
      SCOPE_GLOBAL = 1'b1
   } scope_e;
endpackage

// File: rtl/wbs_popcount.sv
module wbs_popcount #(
   parameter int W = 4,
   localparam int OUT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec,
   output logic [OUT_W-1:0] ones
);
   generate
      if (W < 1) begin : g_bad_w
         $error("wbs_popcount: W must be at least 1");
      end
   endgenerate

   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) begin
         ones = ones + OUT_W'(vec[i]);
      end
   end
endmodule

// File: rtl/wbs_decode.sv
module wbs_decode
   import wbs_pkg::*;
#(
   parameter int NUM_BARRIERS = 4,
   localparam int IDX_W = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1
) (
   input  logic [ID_W-1:0]     bar_id,
   output scope_e              scope,
   output logic [BARNUM_W-1:0] bar_num,
   output logic [IDX_W-1:0]    idx,
   output logic                in_range
);
   always_comb begin
      scope    = scope_e'(bar_id[SCOPE_BIT]);
      bar_num  = bar_id[BARNUM_W-1:0];
      in_range = (bar_num < BARNUM_W'(NUM_BARRIERS));
      idx      = bar_num[IDX_W-1:0];
   end
endmodule

// File: rtl/wbs_mask_bank.sv
module wbs_mask_bank #(
   parameter int NUM_WARPS    = 4,
   parameter int NUM_BARRIERS = 4,
   localparam int IDX_W = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [NUM_WARPS-1:0] rd_mask,
   input  logic                 upd_en,
   input  logic [IDX_W-1:0]     upd_idx,
   input  logic [NUM_WARPS-1:0] upd_mask
);
   logic [NUM_WARPS-1:0] mask_q [NUM_BARRIERS];

   generate
      for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask_q[b] <= '0;
            end else if (upd_en && (upd_idx == IDX_W'(b))) begin
               mask_q[b] <= upd_mask;
            end
         end

         // R10: an entry not named by the update keeps its value
         p_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(upd_en && (upd_idx == IDX_W'(b))) |=> $stable(mask_q[b]));
      end
   endgenerate

   always_comb begin
      rd_mask = '0;
      for (int b = 0; b < NUM_BARRIERS; b++) begin
         if (rd_idx == IDX_W'(b)) rd_mask = mask_q[b];
      end
   end
endmodule

// File: rtl/wbs_release_eval.sv
module wbs_release_eval
   import wbs_pkg::*;
#(
   parameter int NUM_WARPS = 4,
   localparam int CNT_W = $clog2(NUM_WARPS + 1)
) (
   input  logic             take,
   input  scope_e           scope,
   input  logic [CNT_W-1:0] arrived,
   input  logic [CNT_W-1:0] wanted,
   input  logic [CNT_W-1:0] active,
   output logic             fire_local,
   output logic             fire_global
);
   always_comb begin
      fire_local  = take && (scope == SCOPE_LOCAL)  && (arrived == wanted);
      fire_global = take && (scope == SCOPE_GLOBAL) && (arrived == active);
   end
endmodule

// File: rtl/warp_barrier_sync.sv
module warp_barrier_sync
   import wbs_pkg::*;
#(
   parameter int NUM_WARPS    = 4,
   parameter int NUM_BARRIERS = 4,
   parameter int CORE_ID_W    = 8,
   localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int CNT_W = $clog2(NUM_WARPS + 1),
   localparam int IDX_W = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arr_valid,
   input  logic [31:0]          arr_bar_id,
   input  logic [CNT_W-1:0]     arr_count,
   input  logic [WID_W-1:0]     arr_warp,
   input  logic [NUM_WARPS-1:0] active_mask,
   input  logic [CORE_ID_W-1:0] core_id,
   output logic                 resume_valid,
   output logic [NUM_WARPS-1:0] resume_mask,
   output logic                 glb_valid,
   output logic [30:0]          glb_bar,
   output logic [CNT_W-1:0]     glb_count,
   output logic [CORE_ID_W-1:0] glb_core,
   output logic                 bad_index
);
   generate
      if (NUM_WARPS < 1 || NUM_BARRIERS < 1 || CORE_ID_W < 1) begin : g_bad_cfg
         $error("warp_barrier_sync: sizes must be at least 1");
      end
   endgenerate

   scope_e               scope;
   logic [BARNUM_W-1:0]  bar_num;
   logic [IDX_W-1:0]     idx;
   logic                 in_range;
   logic [NUM_WARPS-1:0] cur_mask, warp_bit, nxt_mask, upd_mask;
   logic [CNT_W-1:0]     pc_arrived, pc_active;
   logic                 take, fire_local, fire_global;

   wbs_decode #(.NUM_BARRIERS(NUM_BARRIERS)) u_dec (
      .bar_id(arr_bar_id), .scope(scope), .bar_num(bar_num),
      .idx(idx), .in_range(in_range)
   );

   wbs_mask_bank #(.NUM_WARPS(NUM_WARPS), .NUM_BARRIERS(NUM_BARRIERS)) u_bank (
      .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_mask(cur_mask),
      .upd_en(take), .upd_idx(idx), .upd_mask(upd_mask)
   );

   always_comb begin
      take     = arr_valid && in_range;
      warp_bit = NUM_WARPS'(1) << arr_warp;
      nxt_mask = cur_mask | warp_bit;
   end

   wbs_popcount #(.W(NUM_WARPS)) u_pc_arr (.vec(nxt_mask),    .ones(pc_arrived));
   wbs_popcount #(.W(NUM_WARPS)) u_pc_act (.vec(active_mask), .ones(pc_active));

   wbs_release_eval #(.NUM_WARPS(NUM_WARPS)) u_eval (
      .take(take), .scope(scope), .arrived(pc_arrived), .wanted(arr_count),
      .active(pc_active), .fire_local(fire_local), .fire_global(fire_global)
   );

   assign upd_mask = (fire_local || fire_global) ? '0 : nxt_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resume_valid <= 1'b0;
         resume_mask  <= '0;
         glb_valid    <= 1'b0;
         glb_bar      <= '0;
         glb_count    <= '0;
         glb_core     <= '0;
         bad_index    <= 1'b0;
      end else begin
         resume_valid <= fire_local;
         resume_mask  <= fire_local ? nxt_mask : '0;
         glb_valid    <= fire_global;
         glb_bar      <= fire_global ? bar_num : '0;
         glb_count    <= fire_global ? arr_count : '0;
         glb_core     <= fire_global ? core_id : '0;
         bad_index    <= arr_valid && !in_range;
      end
   end

   // R4: a resume always names at least the warp whose arrival completed it
   p_resume_has_warp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resume_valid |-> resume_mask[$past(arr_warp)]);
   // R8: a bad index produces no completion
   p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_index |-> (!resume_valid && !glb_valid));
   // R6: a global request names a configured barrier
   p_glb_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      glb_valid |-> (glb_bar < 31'(NUM_BARRIERS)));
   // R9: pulses need an accepted arrival in the previous cycle
   p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_valid || glb_valid || bad_index) |-> $past(arr_valid));
   // R9: payload is zero with no pulse
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !resume_valid |-> (resume_mask == '0));
endmodule

// File: tb/tb_warp_barrier_sync.sv
module tb_warp_barrier_sync;
   localparam int NW = 4, NB = 4, CW = 8;
   localparam int WID_W = 2, CNT_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic arr_valid = 1'b0;
   logic [31:0] arr_bar_id = '0;
   logic [CNT_W-1:0] arr_count = '0;
   logic [WID_W-1:0] arr_warp = '0;
   logic [NW-1:0] active_mask = '0;
   logic [CW-1:0] core_id = 8'h5A;
   logic resume_valid, glb_valid, bad_index;
   logic [NW-1:0] resume_mask;
   logic [30:0] glb_bar;
   logic [CNT_W-1:0] glb_count;
   logic [CW-1:0] glb_core;

   int total = 0, bad = 0;
   logic [NW-1:0] model [NB];

   always #5 clk = ~clk;

   warp_barrier_sync #(.NUM_WARPS(NW), .NUM_BARRIERS(NB), .CORE_ID_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_bar_id(arr_bar_id),
      .arr_count(arr_count), .arr_warp(arr_warp), .active_mask(active_mask),
      .core_id(core_id), .resume_valid(resume_valid), .resume_mask(resume_mask),
      .glb_valid(glb_valid), .glb_bar(glb_bar), .glb_count(glb_count),
      .glb_core(glb_core), .bad_index(bad_index)
   );

   function automatic int ones(input logic [NW-1:0] v);
      int n = 0;
      for (int i = 0; i < NW; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_out();
      return {12'd0, bad_index, glb_core, glb_count, glb_bar, glb_valid, resume_mask, resume_valid};
   endfunction

   function automatic logic [63:0] pack_exp(input logic rv, input logic [NW-1:0] rm,
         input logic gv, input logic [30:0] gb, input logic [CNT_W-1:0] gc,
         input logic [CW-1:0] gcore, input logic bi);
      return {12'd0, bi, gcore, gc, gb, gv, rm, rv};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int b = 0; b < NB; b++) model[b] = '0;
   endtask

   // one arrival; the result is sampled one cycle later, then idle is checked
   task automatic arrive(input string req, input logic [31:0] id,
         input int cnt, input int w);
      logic [30:0] num;
      logic [NW-1:0] m;
      logic rv, gv, bi;
      logic [NW-1:0] rm;
      logic [30:0] gb;
      logic [CNT_W-1:0] gc;
      logic [CW-1:0] gcore;
      num = id[30:0];
      rv = 0; gv = 0; bi = 0; rm = '0; gb = '0; gc = '0; gcore = '0;
      if (num >= 31'(NB)) begin
         bi = 1;
      end else begin
         m = model[num] | (NW'(1) << w);
         if (id[31] ? (ones(m) == ones(active_mask)) : (ones(m) == cnt)) begin
            if (id[31]) begin gv = 1; gb = num; gc = CNT_W'(cnt); gcore = core_id; end
            else begin rv = 1; rm = m; end
            model[num] = '0;
         end else begin
            model[num] = m;
         end
      end
      @(negedge clk);
      arr_valid = 1'b1; arr_bar_id = id; arr_count = CNT_W'(cnt); arr_warp = WID_W'(w);
      @(negedge clk);
      arr_valid = 1'b0;
      check(req, pack_out(), pack_exp(rv, rm, gv, gb, gc, gcore, bi));
      @(negedge clk);
      check("R9 one-cycle pulse", pack_out(), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1 reset outputs", pack_out(), 64'd0);

      // R4 R5: every warp subset at every barrier, count = subset size
      for (int b = 0; b < NB; b++)
         for (int s = 1; s < (1 << NW); s++)
            for (int w = 0; w < NW; w++)
               if (s[w]) arrive("R4 R5 local sweep", 32'(b), ones(NW'(s)), w);

      // R3: a repeated warp is counted once
      arrive("R3 first", 32'd0, 2, 1);
      arrive("R3 repeat no release", 32'd0, 2, 1);
      arrive("R3 completes", 32'd0, 2, 2);

      // R6 R7 R2: global sweep over every active mask
      for (int a = 1; a < (1 << NW); a++) begin
         active_mask = NW'(a);
         core_id = CW'(8'h30 + a);
         for (int w = 0; w < NW; w++)
            if (a[w]) arrive("R6 R7 global sweep", 32'h8000_0000 | 32'(a % NB), a % 8, w);
      end
      // R2: same number, local kind, not driven by active mask
      active_mask = 4'b0001;
      arrive("R2 local ignores active", 32'd2, 2, 0);
      arrive("R2 local completes", 32'd2, 2, 3);

      // R10: interleaved barriers stay apart
      arrive("R10 b1 w0", 32'd1, 2, 0);
      arrive("R10 b3 w2", 32'd3, 3, 2);
      arrive("R10 b1 w1", 32'd1, 2, 1);
      arrive("R10 b3 w1", 32'd3, 3, 1);
      arrive("R10 b3 w0", 32'd3, 3, 0);

      // R8: bad numbers change nothing
      arrive("R8 partial", 32'd0, 2, 0);
      arrive("R8 bad low", 32'(NB), 2, 3);
      arrive("R8 bad high", 32'h7FFF_FFFF, 2, 3);
      arrive("R8 bad global", 32'h8000_0000 | 32'(NB), 2, 2);
      arrive("R8 mask intact", 32'd0, 2, 1);

      // R1: reset drops a partial barrier
      arrive("R1 partial", 32'd3, 2, 0);
      do_reset();
      arrive("R1 no stale count", 32'd3, 2, 1);
      arrive("R1 completes", 32'd3, 2, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule